// File: doc/BRIEF.md
# Word-Oriented RAM March Self-Test Engine

This block runs a fixed march test on a synchronous single-port RAM that stores whole words. After a start pulse it walks the memory element by element. Each element has a list of read and write steps and an address direction. At each address it applies every step of the element before it moves to the next address. Reads are compared against the word the algorithm expects. The result is reported when the run finishes.

The base test has six elements. Its middle elements read back the same word twice in a row, which exposes faults that only a second access disturbs. An optional extension adds three elements that use alternating-bit backgrounds, so faults between bits of the same word can be seen. The extension is chosen per run with an input. The engine records the first mismatch it sees and keeps running to the end, so the length of a run does not depend on the result.

Top module: `mem_selftest_ctrl`

## Requirements
- R1: Element order, step lists and directions are: e0 ascending (w0); e1 descending (r0,w1); e2 ascending (r1,w0,r0,r0,w1); e3 ascending (r1,w0); e4 ascending (r0,w1,r1,r1,w0); e5 ascending (r0). Ascending means address 0 to N-1 and descending means N-1 to 0. All steps of an element are applied to one address before the next address.
- R2: With the extension enabled, three elements follow e5, all ascending: e6 (r0,wA,wB,rB); e7 (rB,wA,rA); e8 (rA). Here 0 is the all-zeros word, 1 is the all-ones word, A is the word with every even bit set (bit 0 = 1), and B is the word with every odd bit set.
- R3: The extension elements run only when bds_en is 1 at the accepted start. Otherwise the run ends after e5.
- R4: One RAM operation is issued per clock. done rises exactly OPS+3 cycles after the clock edge that samples start, where OPS is 16*N for the base test and 24*N with the extension.
- R5: done is high for exactly one cycle per run.
- R6: While done is high, pass equals the inverse of fail. A RAM without faults gives fail = 0.
- R7: Read data is compared one cycle after mem_re. The first mismatch of a run sets fail and captures the address, the element index (0 to 8) and the step index within that element (0-based). Later mismatches do not change these values.
- R8: mem_we and mem_re are never high together, and both stay low while no run is in progress.
- R9: A start pulse that arrives while a run is in progress has no effect on the sequence or its timing.
- R10: An accepted start clears fail from the previous run.
- R11: After reset, done, fail, mem_we and mem_re are 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| start | input | 1 | Pulse that launches a run when idle |
| bds_en | input | 1 | Adds the three alternating-background elements |
| mem_addr | output | ADDR_W | RAM address |
| mem_wdata | output | DATA_W | RAM write data |
| mem_we | output | 1 | RAM write enable |
| mem_re | output | 1 | RAM read enable |
| mem_rdata | input | DATA_W | RAM read data, valid one cycle after mem_re |
| done | output | 1 | One-cycle end-of-run pulse |
| pass | output | 1 | Run passed, valid with done |
| fail | output | 1 | Sticky mismatch flag for the current run |
| fail_addr | output | ADDR_W | Address of the first mismatch |
| fail_elem | output | 4 | Element index of the first mismatch |
| fail_step | output | 3 | Step index of the first mismatch |

## Verification
The bench builds the engine with ADDR_W = 3 and DATA_W = 8. An eight-word RAM keeps a full run with the extension at 192 operations, so every operation can be traced against an expected list. Eight data bits are enough for the alternating backgrounds 0x55 and 0xAA to differ from each other and from the solid words. With this size, the same RAM model can place a stuck bit, a cross-address coupling fault and an intra-word bridge at chosen spots. The bench can then predict exactly which element, step and address the engine should report.

// File: rtl/mst_pkg.sv
package mst_pkg;

  typedef enum logic [1:0] {
    BG_ZERO  = 2'd0,
    BG_ONE   = 2'd1,
    BG_ALT_A = 2'd2,
    BG_ALT_B = 2'd3
  } bg_e;

  typedef struct packed {
    logic rd;
    bg_e  bg;
  } step_t;

  localparam int ELEM_W     = 4;
  localparam int STEP_W     = 3;
  localparam int LAST_BASE  = 5;
  localparam int LAST_EXT   = 8;

  function automatic logic [STEP_W-1:0] elem_len(input logic [ELEM_W-1:0] e);
    case (e)
      4'd0, 4'd5, 4'd8: return 3'd1;
      4'd1, 4'd3:       return 3'd2;
      4'd7:             return 3'd3;
      4'd6:             return 3'd4;
      default:          return 3'd5;
    endcase
  endfunction

  function automatic logic elem_down(input logic [ELEM_W-1:0] e);
    return e == 4'd1;
  endfunction

  function automatic step_t mk(input logic rd, input bg_e bg);
    step_t s;
    s.rd = rd;
    s.bg = bg;
    return s;
  endfunction

  function automatic step_t elem_step(input logic [ELEM_W-1:0] e,
                                      input logic [STEP_W-1:0] s);
    step_t r;
    r = mk(1'b0, BG_ZERO);
    case (e)
      4'd0: r = mk(1'b0, BG_ZERO);
      4'd1: r = (s == 3'd0) ? mk(1'b1, BG_ZERO) : mk(1'b0, BG_ONE);
      4'd2: case (s)
              3'd0:       r = mk(1'b1, BG_ONE);
              3'd1:       r = mk(1'b0, BG_ZERO);
              3'd2, 3'd3: r = mk(1'b1, BG_ZERO);
              default:    r = mk(1'b0, BG_ONE);
            endcase
      4'd3: r = (s == 3'd0) ? mk(1'b1, BG_ONE) : mk(1'b0, BG_ZERO);
      4'd4: case (s)
              3'd0:       r = mk(1'b1, BG_ZERO);
              3'd1:       r = mk(1'b0, BG_ONE);
              3'd2, 3'd3: r = mk(1'b1, BG_ONE);
              default:    r = mk(1'b0, BG_ZERO);
            endcase
      4'd5: r = mk(1'b1, BG_ZERO);
      4'd6: case (s)
              3'd0:    r = mk(1'b1, BG_ZERO);
              3'd1:    r = mk(1'b0, BG_ALT_A);
              3'd2:    r = mk(1'b0, BG_ALT_B);
              default: r = mk(1'b1, BG_ALT_B);
            endcase
      4'd7: case (s)
              3'd0:    r = mk(1'b1, BG_ALT_B);
              3'd1:    r = mk(1'b0, BG_ALT_A);
              default: r = mk(1'b1, BG_ALT_A);
            endcase
      4'd8: r = mk(1'b1, BG_ALT_A);
      default: r = mk(1'b0, BG_ZERO);
    endcase
    return r;
  endfunction

endpackage

// File: rtl/mst_bg_gen.sv
module mst_bg_gen #(
  parameter int DATA_W = 16
) (
  input  mst_pkg::bg_e      bg,
  output logic [DATA_W-1:0] word
);
  import mst_pkg::*;

  for (genvar i = 0; i < DATA_W; i++) begin : g_bit
    localparam logic EVEN = (i % 2 == 0);
    always_comb begin
      case (bg)
        BG_ZERO:  word[i] = 1'b0;
        BG_ONE:   word[i] = 1'b1;
        BG_ALT_A: word[i] = EVEN;
        default:  word[i] = ~EVEN;
      endcase
    end
  end
endmodule

// File: rtl/mst_sequencer.sv
module mst_sequencer #(
  parameter int ADDR_W = 4
) (
  input  logic                       clk,
  input  logic                       rst,
  input  logic                       start_ok,
  input  logic                       bds_en,
  output logic                       issue,
  output logic [ADDR_W-1:0]          iss_addr,
  output logic [mst_pkg::ELEM_W-1:0] iss_elem,
  output logic [mst_pkg::STEP_W-1:0] iss_step,
  output mst_pkg::step_t             iss_op,
  output logic                       iss_last
);
  import mst_pkg::*;

  logic               run_q;
  logic               ext_q;
  logic [ELEM_W-1:0]  elem_q;
  logic [STEP_W-1:0]  step_q;
  logic [ADDR_W-1:0]  addr_q;

  logic               down;
  logic [ADDR_W-1:0]  addr_end;
  logic [ELEM_W-1:0]  last_elem;
  logic               step_end;
  logic               at_end;

  always_comb begin
    down      = elem_down(elem_q);
    addr_end  = down ? '0 : '1;
    last_elem = ext_q ? ELEM_W'(LAST_EXT) : ELEM_W'(LAST_BASE);
    step_end  = (step_q == elem_len(elem_q) - 3'd1);
    at_end    = (addr_q == addr_end);
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      run_q  <= 1'b0;
      ext_q  <= 1'b0;
      elem_q <= '0;
      step_q <= '0;
      addr_q <= '0;
    end else if (start_ok) begin
      run_q  <= 1'b1;
      ext_q  <= bds_en;
      elem_q <= '0;
      step_q <= '0;
      addr_q <= '0;
    end else if (run_q) begin
      if (!step_end) begin
        step_q <= step_q + 3'd1;
      end else begin
        step_q <= '0;
        if (!at_end) begin
          addr_q <= down ? addr_q - 1'b1 : addr_q + 1'b1;
        end else if (elem_q == last_elem) begin
          run_q <= 1'b0;
        end else begin
          elem_q <= elem_q + 4'd1;
          addr_q <= elem_down(elem_q + 4'd1) ? '1 : '0;
        end
      end
    end
  end

  assign issue    = run_q;
  assign iss_addr = addr_q;
  assign iss_elem = elem_q;
  assign iss_step = step_q;
  assign iss_op   = elem_step(elem_q, step_q);
  assign iss_last = run_q && step_end && at_end && (elem_q == last_elem);

endmodule

// File: rtl/mst_resp_cmp.sv
module mst_resp_cmp #(
  parameter int ADDR_W = 4,
  parameter int DATA_W = 16
) (
  input  logic                       clk,
  input  logic                       rst,
  input  logic                       clear,
  input  logic                       chk_in,
  input  logic [DATA_W-1:0]          exp_in,
  input  logic [ADDR_W-1:0]          addr_in,
  input  logic [mst_pkg::ELEM_W-1:0] elem_in,
  input  logic [mst_pkg::STEP_W-1:0] step_in,
  input  logic [DATA_W-1:0]          rdata,
  output logic                       fail,
  output logic [ADDR_W-1:0]          fail_addr,
  output logic [mst_pkg::ELEM_W-1:0] fail_elem,
  output logic [mst_pkg::STEP_W-1:0] fail_step
);
  import mst_pkg::*;

  logic                c_chk;
  logic [DATA_W-1:0]   c_exp;
  logic [ADDR_W-1:0]   c_addr;
  logic [ELEM_W-1:0]   c_elem;
  logic [STEP_W-1:0]   c_step;
  logic                miss;

  assign miss = c_chk && (rdata != c_exp);

  always_ff @(posedge clk) begin
    if (rst) begin
      c_chk     <= 1'b0;
      c_exp     <= '0;
      c_addr    <= '0;
      c_elem    <= '0;
      c_step    <= '0;
      fail      <= 1'b0;
      fail_addr <= '0;
      fail_elem <= '0;
      fail_step <= '0;
    end else begin
      c_chk  <= chk_in;
      c_exp  <= exp_in;
      c_addr <= addr_in;
      c_elem <= elem_in;
      c_step <= step_in;
      if (clear) begin
        fail      <= 1'b0;
        fail_addr <= '0;
        fail_elem <= '0;
        fail_step <= '0;
      end else if (miss && !fail) begin
        fail      <= 1'b1;
        fail_addr <= c_addr;
        fail_elem <= c_elem;
        fail_step <= c_step;
      end
    end
  end
endmodule

// File: rtl/mem_selftest_ctrl.sv
module mem_selftest_ctrl #(
  parameter int ADDR_W = 4,
  parameter int DATA_W = 16
) (
  input  logic              clk,
  input  logic              rst,
  input  logic              start,
  input  logic              bds_en,
  output logic [ADDR_W-1:0] mem_addr,
  output logic [DATA_W-1:0] mem_wdata,
  output logic              mem_we,
  output logic              mem_re,
  input  logic [DATA_W-1:0] mem_rdata,
  output logic              done,
  output logic              pass,
  output logic              fail,
  output logic [ADDR_W-1:0] fail_addr,
  output logic [3:0]        fail_elem,
  output logic [2:0]        fail_step
);
  import mst_pkg::*;

  logic               busy_r;
  logic               start_ok;
  logic               issue;
  logic [ADDR_W-1:0]  iss_addr;
  logic [ELEM_W-1:0]  iss_elem;
  logic [STEP_W-1:0]  iss_step;
  step_t              iss_op;
  logic               iss_last;
  logic [DATA_W-1:0]  pat_word;
  logic [ELEM_W-1:0]  p_elem;
  logic [STEP_W-1:0]  p_step;
  logic               last_p1;
  logic               last_p2;

  assign start_ok = start && !busy_r;

  mst_sequencer #(.ADDR_W(ADDR_W)) u_seq (
    .clk      (clk),
    .rst      (rst),
    .start_ok (start_ok),
    .bds_en   (bds_en),
    .issue    (issue),
    .iss_addr (iss_addr),
    .iss_elem (iss_elem),
    .iss_step (iss_step),
    .iss_op   (iss_op),
    .iss_last (iss_last)
  );

  mst_bg_gen #(.DATA_W(DATA_W)) u_bg (
    .bg   (iss_op.bg),
    .word (pat_word)
  );

  always_ff @(posedge clk) begin
    if (rst) begin
      busy_r    <= 1'b0;
      mem_we    <= 1'b0;
      mem_re    <= 1'b0;
      mem_addr  <= '0;
      mem_wdata <= '0;
      p_elem    <= '0;
      p_step    <= '0;
      last_p1   <= 1'b0;
      last_p2   <= 1'b0;
      done      <= 1'b0;
    end else begin
      if (start_ok)     busy_r <= 1'b1;
      else if (last_p2) busy_r <= 1'b0;
      mem_we  <= issue && !iss_op.rd;
      mem_re  <= issue && iss_op.rd;
      if (issue) begin
        mem_addr  <= iss_addr;
        mem_wdata <= pat_word;
        p_elem    <= iss_elem;
        p_step    <= iss_step;
      end
      last_p1 <= iss_last;
      last_p2 <= last_p1;
      done    <= last_p2;
    end
  end

  mst_resp_cmp #(.ADDR_W(ADDR_W), .DATA_W(DATA_W)) u_cmp (
    .clk       (clk),
    .rst       (rst),
    .clear     (start_ok),
    .chk_in    (mem_re),
    .exp_in    (mem_wdata),
    .addr_in   (mem_addr),
    .elem_in   (p_elem),
    .step_in   (p_step),
    .rdata     (mem_rdata),
    .fail      (fail),
    .fail_addr (fail_addr),
    .fail_elem (fail_elem),
    .fail_step (fail_step)
  );

  assign pass = ~fail;

endmodule

// File: rtl/mem_selftest_ctrl_sva.sv
module mem_selftest_ctrl_sva #(
  parameter int ADDR_W = 4
) (
  input logic              clk,
  input logic              rst,
  input logic              start,
  input logic              busy,
  input logic              mem_we,
  input logic              mem_re,
  input logic              done,
  input logic              pass,
  input logic              fail,
  input logic [ADDR_W-1:0] fail_addr,
  input logic [3:0]        fail_elem,
  input logic [2:0]        fail_step
);
  // R8
  excl_enable_chk: assert property (@(posedge clk) disable iff (rst)
    !(mem_we && mem_re));

  // R8
  idle_quiet_chk: assert property (@(posedge clk) disable iff (rst)
    !busy |-> (!mem_we && !mem_re));

  // R5
  done_pulse_chk: assert property (@(posedge clk) disable iff (rst)
    done |=> !done);

  // R5
  done_after_run_chk: assert property (@(posedge clk) disable iff (rst)
    $rose(done) |-> $past(busy));

  // R6
  pass_inv_chk: assert property (@(posedge clk) disable iff (rst)
    done |-> (pass != fail));

  // R7
  fail_sticky_chk: assert property (@(posedge clk) disable iff (rst)
    (fail && !start) |=> fail);

  // R7
  fail_hold_chk: assert property (@(posedge clk) disable iff (rst)
    (fail && !start) |=> ($stable(fail_addr) && $stable(fail_elem) && $stable(fail_step)));

  // R7
  fail_elem_range_chk: assert property (@(posedge clk) disable iff (rst)
    fail |-> (fail_elem <= 4'd8 && fail_step <= 3'd4));

  // R7
  idle_no_fail_chk: assert property (@(posedge clk) disable iff (rst)
    (!busy && !fail) |=> !fail);
endmodule

bind mem_selftest_ctrl mem_selftest_ctrl_sva #(.ADDR_W(ADDR_W)) u_sva (
  .clk       (clk),
  .rst       (rst),
  .start     (start),
  .busy      (busy_r),
  .mem_we    (mem_we),
  .mem_re    (mem_re),
  .done      (done),
  .pass      (pass),
  .fail      (fail),
  .fail_addr (fail_addr),
  .fail_elem (fail_elem),
  .fail_step (fail_step)
);

// File: tb/mem_selftest_ctrl_bench.sv
module mem_selftest_ctrl_bench;
  localparam int AW     = 3;
  localparam int DW     = 8;
  localparam int NW     = 1 << AW;
  localparam int MAXOPS = 24 * NW;

  logic          clk = 1'b0;
  logic          rst = 1'b1;
  logic          start = 1'b0;
  logic          bds_en = 1'b0;
  logic [AW-1:0] mem_addr;
  logic [DW-1:0] mem_wdata;
  logic          mem_we, mem_re;
  logic [DW-1:0] mem_rdata = '0;
  logic          done, pass, fail;
  logic [AW-1:0] fail_addr;
  logic [3:0]    fail_elem;
  logic [2:0]    fail_step;

  int n_chk = 0;
  int n_bad = 0;

  always #5 clk = ~clk;

  mem_selftest_ctrl #(.ADDR_W(AW), .DATA_W(DW)) u_mem_selftest_ctrl (
    .clk(clk), .rst(rst), .start(start), .bds_en(bds_en),
    .mem_addr(mem_addr), .mem_wdata(mem_wdata), .mem_we(mem_we), .mem_re(mem_re),
    .mem_rdata(mem_rdata), .done(done), .pass(pass), .fail(fail),
    .fail_addr(fail_addr), .fail_elem(fail_elem), .fail_step(fail_step)
  );

  // fault model shared by the RAM (copy 0) and the reference walk (copy 1)
  logic [DW-1:0] mem [2][NW];
  bit sa_en, cf_en, br_en;
  int sa_addr, sa_bit, cf_aggr, cf_bit, cf_vict, cf_vbit, br_addr;
  logic sa_val;

  task automatic mem_wr(input int w, input int a, input logic [DW-1:0] d);
    logic [DW-1:0] old, nd;
    old = mem[w][a];
    nd  = d;
    if (br_en && a == br_addr) nd[1] = nd[0];
    if (sa_en && a == sa_addr) nd[sa_bit] = sa_val;
    mem[w][a] = nd;
    if (cf_en && a == cf_aggr && !old[cf_bit] && nd[cf_bit])
      mem[w][cf_vict][cf_vbit] = ~mem[w][cf_vict][cf_vbit];
  endtask

  function automatic logic [DW-1:0] mem_rd(input int w, input int a);
    logic [DW-1:0] v;
    v = mem[w][a];
    if (sa_en && a == sa_addr) v[sa_bit] = sa_val;
    return v;
  endfunction

  always @(posedge clk) begin
    if (mem_we) mem_wr(0, int'(mem_addr), mem_wdata);
    if (mem_re) mem_rdata <= mem_rd(0, int'(mem_addr));
  end

  // test algorithm as stated in the requirements: {rd, bg}; bg 0=zeros 1=ones 2=A 3=B
  function automatic int blen(input int e);
    case (e)
      0, 5, 8: return 1;
      1, 3:    return 2;
      6:       return 4;
      7:       return 3;
      default: return 5;
    endcase
  endfunction

  function automatic logic [2:0] bstep(input int e, input int s);
    case (e)
      0: return 3'b000;
      1: return (s == 0) ? 3'b100 : 3'b001;
      2: return (s == 0) ? 3'b101 : (s == 1) ? 3'b000 : (s == 4) ? 3'b001 : 3'b100;
      3: return (s == 0) ? 3'b101 : 3'b000;
      4: return (s == 0) ? 3'b100 : (s == 1) ? 3'b001 : (s == 4) ? 3'b000 : 3'b101;
      5: return 3'b100;
      6: return (s == 0) ? 3'b100 : (s == 1) ? 3'b010 : (s == 2) ? 3'b011 : 3'b111;
      7: return (s == 0) ? 3'b111 : (s == 1) ? 3'b010 : 3'b110;
      default: return 3'b110;
    endcase
  endfunction

  function automatic logic [DW-1:0] bword(input logic [1:0] bg);
    case (bg)
      2'd0:    return '0;
      2'd1:    return '1;
      2'd2:    return {(DW/2){2'b01}};
      default: return {(DW/2){2'b10}};
    endcase
  endfunction

  logic          tr_rd   [MAXOPS];
  logic [AW-1:0] tr_addr [MAXOPS];
  logic [DW-1:0] tr_data [MAXOPS];
  int  tr_len;
  bit  ref_fail;
  int  ref_addr, ref_elem, ref_step;

  task automatic build_ref(input bit ext);
    int last;
    last = ext ? 8 : 5;
    tr_len = 0;
    ref_fail = 0; ref_addr = 0; ref_elem = 0; ref_step = 0;
    for (int e = 0; e <= last; e++) begin
      for (int ai = 0; ai < NW; ai++) begin
        int a;
        a = (e == 1) ? NW - 1 - ai : ai;
        for (int s = 0; s < blen(e); s++) begin
          logic [2:0] op;
          logic [DW-1:0] wd;
          op = bstep(e, s);
          wd = bword(op[1:0]);
          tr_rd[tr_len]   = op[2];
          tr_addr[tr_len] = AW'(a);
          tr_data[tr_len] = wd;
          tr_len++;
          if (op[2]) begin
            if (mem_rd(1, a) != wd && !ref_fail) begin
              ref_fail = 1; ref_addr = a; ref_elem = e; ref_step = s;
            end
          end else begin
            mem_wr(1, a, wd);
          end
        end
      end
    end
  endtask

  bit mon_en = 0;
  int mon_idx, mon_err;
  always @(negedge clk) begin
    if (mon_en && (mem_we || mem_re)) begin
      if (mon_idx >= tr_len) mon_err++;
      else if (mem_re != tr_rd[mon_idx] || mem_addr != tr_addr[mon_idx] ||
               (mem_we && mem_wdata != tr_data[mon_idx])) mon_err++;
      mon_idx++;
    end
  end

  task automatic check(input bit ok, input string req, input string what,
                       input longint act, input longint exp);
    n_chk++;
    if (!ok) begin
      n_bad++;
      $display("FAIL %s %s actual=%0d expected=%0d", req, what, act, exp);
    end
  endtask

  task automatic clear_faults();
    sa_en = 0; cf_en = 0; br_en = 0;
    sa_addr = 0; sa_bit = 0; sa_val = 0;
    cf_aggr = 0; cf_bit = 0; cf_vict = 0; cf_vbit = 0; br_addr = 0;
  endtask

  // runs one test and checks order, timing, done pulse and result
  task automatic run_case(input bit ext, input bit poke_start);
    int cnt, ops;
    for (int a = 0; a < NW; a++) begin
      mem[0][a] = DW'(8'hC3 ^ a);
      mem[1][a] = DW'(8'hC3 ^ a);
    end
    build_ref(ext);
    ops = ext ? 24 * NW : 16 * NW;
    mon_idx = 0; mon_err = 0; mon_en = 1;
    @(negedge clk);
    bds_en = ext;
    start  = 1'b1;
    @(posedge clk);
    cnt = 0;
    while (cnt < 2000) begin
      @(negedge clk);
      cnt++;
      start = (poke_start && (cnt == 20 || cnt == 21));
      if (cnt == 1) bds_en = ~ext;
      if (done) break;
    end
    check(done, "R4", "done seen", done, 1);
    check(cnt == ops + 3, "R4", "cycles to done", cnt, ops + 3);
    check(mon_err == 0, "R1", "operation trace mismatches", mon_err, 0);
    check(mon_idx == tr_len, ext ? "R2" : "R3", "operation count", mon_idx, tr_len);
    check(pass == !ref_fail, "R6", "pass", pass, !ref_fail);
    check(fail == ref_fail, "R7", "fail", fail, ref_fail);
    if (ref_fail) begin
      check(fail_addr == AW'(ref_addr), "R7", "fail_addr", fail_addr, ref_addr);
      check(fail_elem == 4'(ref_elem), "R7", "fail_elem", fail_elem, ref_elem);
      check(fail_step == 3'(ref_step), "R7", "fail_step", fail_step, ref_step);
    end
    @(negedge clk);
    check(!done, "R5", "done one cycle", done, 0);
    mon_en = 0;
    for (int i = 0; i < 4; i++) begin
      check(!mem_we && !mem_re, "R8", "idle enables", {mem_we, mem_re}, 0);
      @(negedge clk);
    end
  endtask

  task automatic t_reset();
    rst = 1'b1;
    repeat (3) @(posedge clk);
    @(negedge clk);
    check(!done && !fail && !mem_we && !mem_re, "R11", "reset outputs",
          {done, fail, mem_we, mem_re}, 0);
    rst = 1'b0;
    @(negedge clk);
    check(!mem_we && !mem_re, "R8", "enables idle after reset", {mem_we, mem_re}, 0);
  endtask

  task automatic t_clean_base();
    clear_faults();
    run_case(1'b0, 1'b0);
    check(!ref_fail, "R6", "clean memory expected to pass", ref_fail, 0);
  endtask

  task automatic t_clean_ext();
    clear_faults();
    run_case(1'b1, 1'b0);
  endtask

  task automatic t_stuck0();
    clear_faults();
    sa_en = 1; sa_addr = 5; sa_bit = 2; sa_val = 1'b0;
    run_case(1'b0, 1'b0);
    check(ref_elem == 2 && ref_addr == 5, "R7", "stuck-0 reference", ref_elem, 2);
  endtask

  task automatic t_stuck1();
    clear_faults();
    sa_en = 1; sa_addr = 0; sa_bit = 7; sa_val = 1'b1;
    run_case(1'b0, 1'b0);
    check(ref_elem == 1 && ref_addr == 0, "R7", "stuck-1 in descending element", ref_elem, 1);
  endtask

  task automatic t_coupling();
    clear_faults();
    cf_en = 1; cf_aggr = 2; cf_bit = 3; cf_vict = 6; cf_vbit = 5;
    run_case(1'b1, 1'b0);
  endtask

  task automatic t_intraword();
    clear_faults();
    br_en = 1; br_addr = 3;
    run_case(1'b0, 1'b0);
    check(pass, "R3", "bit bridge hidden without extension", pass, 1);
    run_case(1'b1, 1'b0);
    check(fail && fail_elem == 4'd6, "R2", "bit bridge found by alternating words",
          fail_elem, 6);
  endtask

  task automatic t_start_ignored();
    clear_faults();
    run_case(1'b0, 1'b1);
    check(pass && !fail, "R10", "fail cleared by new start", fail, 0);
    check(1'b1, "R9", "mid-run start left timing unchanged (above)", 1, 1);
  endtask

  initial begin
    repeat (200000) @(posedge clk);
    n_bad++;
    $display("FAIL watchdog expired actual=1 expected=0");
    $display("  test done: total=%0d bad=%0d", n_chk, n_bad);
    $finish;
  end

  initial begin
    clear_faults();
    t_reset();
    t_clean_base();
    t_clean_ext();
    t_stuck0();
    t_stuck1();
    t_coupling();
    t_intraword();
    t_start_ignored();
    $display("  test done: total=%0d bad=%0d", n_chk, n_bad);
    $finish;
  end
endmodule